// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

This block sits between a cache miss handler and a 64-bit memory bus and turns one line fill request into four data beats. A line holds eight 32-bit words, so every beat moves an aligned pair of words. The block does not start the burst at pair 0. It starts at the pair that holds the word the stalled read is waiting for, then steps upward through the pairs and wraps back to pair 0. For example, a request for word 5 fetches pairs (4,5), (6,7), (0,1) and then (2,3).

Each returned beat is handed to the cache fill port as two tagged word slots. In the first beat the requested word is placed in slot 0, ahead of its partner. A one-cycle strobe marks the moment that word is available and carries its value, so the pipeline can resume before the rest of the line has arrived. A second strobe marks the end of the line. A new request is taken only when no burst is in progress. It can be taken in the same cycle as the end-of-line strobe.

Top module: `cwf_burst_seq`

## Requirements
- R1: `reqReady` is high exactly when no burst is in progress. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high, and `busReq` rises in the next cycle.
- R2: The first beat address is the byte address `{reqLineAddr, reqWord[2:1], 3'b000}`, which is the aligned pair that holds the requested word.
- R3: A burst has exactly four beats. After each accepted beat, the pair index in `busAddr[4:3]` increases by one modulo 4. After the fourth beat `busReq` falls.
- R4: While `busReq` is high and no `busRdValid` arrives, `busAddr` holds steady and `busReq` stays high.
- R5: One cycle after each beat is accepted, `fillValid` is high for one cycle. `busRdData[31:0]` carries the even word of the pair and `busRdData[63:32]` carries the odd word. Slot 0 is `fillData[31:0]` with index `fillIdx[2:0]`. Slot 1 is `fillData[63:32]` with index `fillIdx[5:3]`. In later beats slot 0 holds the even word.
- R6: In the first beat, slot 0 holds the requested word and slot 1 holds its partner. `critVld` pulses for one cycle together with that fill, and `critData` equals the requested word.
- R7: `lineDone` pulses for one cycle together with the fourth fill. `reqReady` is already high in that cycle, and a request presented then is accepted.
- R8: A `busRdValid` that arrives while `busReq` is low is ignored. No fill follows it and no burst starts.
- R9: A `reqValid` that arrives during a burst is ignored. The burst's addresses are unchanged and no further burst starts after it.
- R10: After reset, `reqReady` is 1 and `busReq`, `fillValid`, `critVld` and `lineDone` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Fill request present |
| reqReady | output | 1 | Sequencer idle, able to take a request |
| reqLineAddr | input | 27 | Line address (byte address bits 31:5) |
| reqWord | input | 3 | Index of the requested word in the line |
| busReq | output | 1 | Beat address valid, waiting for data |
| busAddr | output | 32 | Byte address of the current beat |
| busRdValid | input | 1 | Beat data returned |
| busRdData | input | 64 | Beat data, even word in the low half |
| fillValid | output | 1 | Fill slots valid |
| fillData | output | 64 | Two fill word slots, slot 0 in the low half |
| fillIdx | output | 6 | Word index of each slot, slot 0 in bits 2:0 |
| critVld | output | 1 | Requested word available this cycle |
| critData | output | 32 | Requested word |
| lineDone | output | 1 | Last beat of the line delivered this cycle |

## Verification
The end-of-line strobe and the acceptance of the next request can fall in the same cycle, because the sequencer is already idle when the last fill leaves its output registers. The bench provokes this by presenting a new request exactly in the cycle where `lineDone` is expected. It then checks that the old line's last fill is intact, and that the next cycle shows the new request's critical pair on `busAddr`. Beat data is returned both back-to-back and with gaps, so the address step and the fill output are also checked in the same cycle as the next beat's capture.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_BURST = 1'b1
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // request accepted this cycle
    logic capture;  // beat data taken this cycle
    logic first;    // captured beat is the critical one
    logic last;     // captured beat ends the line
  } cwfStrb_t;

endpackage

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
  import cwf_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     busRdValid,
  output logic     reqReady,
  output logic     busReq,
  output cwfStrb_t strb
);

  seqState_t stateQ;
  logic [CNT_W-1:0] beatCnt;

  always_comb begin
    reqReady     = (stateQ == SEQ_IDLE);
    busReq       = (stateQ == SEQ_BURST);
    strb.load    = reqReady && reqValid;
    strb.capture = busReq && busRdValid;
    strb.first   = strb.capture && (beatCnt == '0);
    strb.last    = strb.capture && (beatCnt == CNT_W'(BEATS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= SEQ_IDLE;
      beatCnt <= '0;
    end else if (strb.load) begin
      stateQ  <= SEQ_BURST;
      beatCnt <= '0;
    end else if (strb.capture) begin
      beatCnt <= beatCnt + 1'b1;
      if (strb.last) stateQ <= SEQ_IDLE;
    end
  end

endmodule

// File: rtl/cwf_datapath.sv
module cwf_datapath
  import cwf_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int WORD_W         = 32,
  parameter int WORDS_PER_BEAT = 2,
  parameter int BEATS          = 4,
  localparam int SUB_W    = $clog2(WORDS_PER_BEAT),
  localparam int BEAT_W   = $clog2(BEATS),
  localparam int WIDX_W   = SUB_W + BEAT_W,
  localparam int BYTE_OFF = $clog2(WORDS_PER_BEAT * WORD_W / 8),
  localparam int LINE_OFF = BYTE_OFF + BEAT_W,
  localparam int LINE_W   = ADDR_W - LINE_OFF,
  localparam int BUS_W    = WORDS_PER_BEAT * WORD_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cwfStrb_t                         strb,
  input  logic [LINE_W-1:0]                reqLineAddr,
  input  logic [WIDX_W-1:0]                reqWord,
  input  logic [BUS_W-1:0]                 busRdData,
  output logic [ADDR_W-1:0]                busAddr,
  output logic                             fillValid,
  output logic [BUS_W-1:0]                 fillData,
  output logic [WORDS_PER_BEAT*WIDX_W-1:0] fillIdx,
  output logic                             critVld,
  output logic [WORD_W-1:0]                critData,
  output logic                             lineDone
);

  logic [LINE_W-1:0] lineQ;
  logic [BEAT_W-1:0] beatQ;
  logic [SUB_W-1:0]  subQ;
  logic [SUB_W-1:0]  rot;

  logic [BUS_W-1:0]                 slotData;
  logic [WORDS_PER_BEAT*WIDX_W-1:0] slotIdx;

  assign busAddr = {lineQ, beatQ, {BYTE_OFF{1'b0}}};
  // only the critical beat is rotated so the requested word leads
  assign rot = strb.first ? subQ : '0;

  for (genvar k = 0; k < WORDS_PER_BEAT; k++) begin : g_slot
    logic [SUB_W-1:0] lane;
    always_comb begin
      lane = rot + SUB_W'(k);
      slotData[k*WORD_W +: WORD_W] = busRdData[lane*WORD_W +: WORD_W];
      slotIdx[k*WIDX_W +: WIDX_W]  = {beatQ, lane};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ <= '0;
      beatQ <= '0;
      subQ  <= '0;
    end else if (strb.load) begin
      lineQ <= reqLineAddr;
      beatQ <= reqWord[WIDX_W-1:SUB_W];
      subQ  <= reqWord[SUB_W-1:0];
    end else if (strb.capture) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillValid <= 1'b0;
      critVld   <= 1'b0;
      lineDone  <= 1'b0;
      fillData  <= '0;
      fillIdx   <= '0;
      critData  <= '0;
    end else begin
      fillValid <= strb.capture;
      critVld   <= strb.first;
      lineDone  <= strb.last;
      if (strb.capture) begin
        fillData <= slotData;
        fillIdx  <= slotIdx;
      end
      if (strb.first) critData <= slotData[WORD_W-1:0];
    end
  end

endmodule

// File: rtl/cwf_burst_seq.sv
module cwf_burst_seq
  import cwf_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int WORD_W         = 32,
  parameter int WORDS_PER_BEAT = 2,
  parameter int BEATS          = 4,
  localparam int SUB_W    = $clog2(WORDS_PER_BEAT),
  localparam int BEAT_W   = $clog2(BEATS),
  localparam int WIDX_W   = SUB_W + BEAT_W,
  localparam int LINE_OFF = $clog2(WORDS_PER_BEAT * WORD_W / 8) + BEAT_W,
  localparam int LINE_W   = ADDR_W - LINE_OFF,
  localparam int BUS_W    = WORDS_PER_BEAT * WORD_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  output logic                             reqReady,
  input  logic [LINE_W-1:0]                reqLineAddr,
  input  logic [WIDX_W-1:0]                reqWord,
  output logic                             busReq,
  output logic [ADDR_W-1:0]                busAddr,
  input  logic                             busRdValid,
  input  logic [BUS_W-1:0]                 busRdData,
  output logic                             fillValid,
  output logic [BUS_W-1:0]                 fillData,
  output logic [WORDS_PER_BEAT*WIDX_W-1:0] fillIdx,
  output logic                             critVld,
  output logic [WORD_W-1:0]                critData,
  output logic                             lineDone
);

  cwfStrb_t strb;

  cwf_ctrl #(.BEATS(BEATS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .busRdValid (busRdValid),
    .reqReady   (reqReady),
    .busReq     (busReq),
    .strb       (strb)
  );

  cwf_datapath #(
    .ADDR_W         (ADDR_W),
    .WORD_W         (WORD_W),
    .WORDS_PER_BEAT (WORDS_PER_BEAT),
    .BEATS          (BEATS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqLineAddr (reqLineAddr),
    .reqWord     (reqWord),
    .busRdData   (busRdData),
    .busAddr     (busAddr),
    .fillValid   (fillValid),
    .fillData    (fillData),
    .fillIdx     (fillIdx),
    .critVld     (critVld),
    .critData    (critData),
    .lineDone    (lineDone)
  );

endmodule

// File: rtl/cwf_burst_seq_chk.sv
module cwf_burst_seq_chk #(
  parameter int ADDR_W         = 32,
  parameter int WORDS_PER_BEAT = 2,
  parameter int BEATS          = 4,
  parameter int WORD_W         = 32,
  localparam int BEAT_W   = $clog2(BEATS),
  localparam int BYTE_OFF = $clog2(WORDS_PER_BEAT * WORD_W / 8)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              busReq,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRdValid,
  input logic              fillValid,
  input logic              critVld,
  input logic              lineDone
);

  AST_IDLE_XOR_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    reqReady != busReq); // R1

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busRdValid) |=> (!busReq ||
      busAddr[BYTE_OFF +: BEAT_W] == BEAT_W'($past(busAddr[BYTE_OFF +: BEAT_W]) + 1'b1))); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busRdValid) |=> (busReq && $stable(busAddr))); // R4

  AST_FILL_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busRdValid) |=> fillValid); // R5

  AST_CRIT_WITH_FILL: assert property (@(posedge clk) disable iff (!rstN)
    critVld |-> (fillValid && !lineDone)); // R6

  AST_CRIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    critVld |=> !critVld); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> (fillValid && reqReady)); // R7

  AST_IDLE_DATA_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!busReq && busRdValid) |=> !fillValid); // R8

endmodule

bind cwf_burst_seq cwf_burst_seq_chk #(
  .ADDR_W         (ADDR_W),
  .WORDS_PER_BEAT (WORDS_PER_BEAT),
  .BEATS          (BEATS),
  .WORD_W         (WORD_W)
) chk_i (.*);

// File: tb/cwf_burst_seq_tb_top.sv
module cwf_burst_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [26:0] reqLineAddr = '0;
  logic [2:0]  reqWord = '0;
  logic        busReq;
  logic [31:0] busAddr;
  logic        busRdValid = 1'b0;
  logic [63:0] busRdData = '0;
  logic        fillValid;
  logic [63:0] fillData;
  logic [5:0]  fillIdx;
  logic        critVld;
  logic [31:0] critData;
  logic        lineDone;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cwf_burst_seq dut_i (.*);

  // stimulus table: {line[15:0], word[2:0], gap[1:0]}
  localparam int NVEC = 8;
  localparam logic [20:0] VECS [NVEC] = '{
    {16'h0123, 3'd5, 2'd0},
    {16'h0040, 3'd0, 2'd1},
    {16'h7FFF, 3'd7, 2'd0},
    {16'h1A2B, 3'd2, 2'd2},
    {16'h0000, 3'd3, 2'd0},
    {16'hBEEF, 3'd6, 2'd1},
    {16'h0F0F, 3'd1, 2'd0},
    {16'h5555, 3'd4, 2'd3}
  };

  function automatic logic [31:0] wv(input logic [26:0] l, input logic [2:0] k);
    return {l[15:0], 8'hC3, 5'd0, k};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [26:0] l, input logic [2:0] w);
    reqValid    = 1'b1;
    reqLineAddr = l;
    reqWord     = w;
  endtask

  // called at the negedge right after the issue; ends at the negedge of lineDone
  task automatic burst(input logic [26:0] l, input logic [2:0] w, input int gap,
                       input bit poke, input bit chain,
                       input logic [26:0] cl, input logic [2:0] cw);
    logic [1:0] p;
    logic       sw;
    logic [2:0] i0, i1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int b = 0; b < 4; b++) begin
      repeat (gap) @(negedge clk);
      p  = 2'(w[2:1] + 2'(b));
      sw = (b == 0) ? w[0] : 1'b0;
      i0 = {p, sw};
      i1 = {p, ~sw};
      if (poke && b == 1) begin
        chk(reqReady == 1'b0, "R9 ready low while busy", 64'(reqReady), 64'd0);
        issue(~l, ~w);
      end
      chk(busReq == 1'b1, "R4 busReq held", 64'(busReq), 64'd1);
      chk(busAddr == {l, p, 3'b000}, (b == 0) ? "R2 first beat addr" : "R3 beat addr",
          64'(busAddr), 64'({l, p, 3'b000}));
      busRdValid = 1'b1;
      busRdData  = {wv(l, {p, 1'b1}), wv(l, {p, 1'b0})};
      @(negedge clk);
      busRdValid = 1'b0;
      reqValid   = 1'b0;
      chk(fillValid == 1'b1, "R5 fillValid", 64'(fillValid), 64'd1);
      chk(fillIdx == {i1, i0}, (b == 0) ? "R6 crit slot order" : "R5 fill idx",
          64'(fillIdx), 64'({i1, i0}));
      chk(fillData == {wv(l, i1), wv(l, i0)}, "R5 fill data",
          fillData, {wv(l, i1), wv(l, i0)});
      chk(critVld == (b == 0), "R6 critVld", 64'(critVld), 64'(b == 0));
      if (b == 0)
        chk(critData == wv(l, w), "R6 critData", 64'(critData), 64'(wv(l, w)));
      chk(lineDone == (b == 3), "R7 lineDone", 64'(lineDone), 64'(b == 3));
      if (b == 3) begin
        chk(reqReady == 1'b1, "R7 ready at done", 64'(reqReady), 64'd1);
        chk(busReq == 1'b0, "R3 busReq falls", 64'(busReq), 64'd0);
        if (chain) issue(cl, cw);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(reqReady == 1'b1, "R10 reqReady", 64'(reqReady), 64'd1);
    chk(busReq == 1'b0, "R10 busReq", 64'(busReq), 64'd0);
    chk(fillValid == 1'b0, "R10 fillValid", 64'(fillValid), 64'd0);
    chk(critVld == 1'b0, "R10 critVld", 64'(critVld), 64'd0);
    chk(lineDone == 1'b0, "R10 lineDone", 64'(lineDone), 64'd0);

    // table walk (R1 accept, R2..R7)
    for (int v = 0; v < NVEC; v++) begin
      issue(27'(VECS[v][20:5]), VECS[v][4:2]);
      burst(27'(VECS[v][20:5]), VECS[v][4:2], int'(VECS[v][1:0]), 1'b0, 1'b0, '0, '0);
      @(negedge clk);
      chk(busReq == 1'b0, "R1 idle after burst", 64'(busReq), 64'd0);
    end

    // R8: data while idle is dropped
    busRdValid = 1'b1;
    busRdData  = 64'hDEAD_BEEF_0BAD_F00D;
    @(negedge clk);
    busRdValid = 1'b0;
    chk(fillValid == 1'b0, "R8 no fill from idle data", 64'(fillValid), 64'd0);
    chk(busReq == 1'b0, "R8 no burst from idle data", 64'(busReq), 64'd0);

    // R9: request during burst is ignored
    issue(27'h0333, 3'd3);
    burst(27'h0333, 3'd3, 1, 1'b1, 1'b0, '0, '0);
    @(negedge clk);
    chk(busReq == 1'b0, "R9 no stray burst", 64'(busReq), 64'd0);

    // R7: new request accepted in the lineDone cycle
    issue(27'h2222, 3'd7);
    burst(27'h2222, 3'd7, 0, 1'b0, 1'b1, 27'h4444, 3'd2);
    burst(27'h4444, 3'd2, 0, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after chain", 64'(reqReady), 64'd1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule